// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Pair with Watermark Interrupt

This block sits between a simple register bus and an SPI shift engine. It holds two byte-wide queues of parameterised depth (8 entries by default). Software writes bytes into the transmit queue through a data register, and the shift engine drains them. The shift engine fills the receive queue with each frame it captures, and software drains it through a second data register. The full or empty status of each queue comes back in bit 31 of the same word as the data. Software therefore needs no separate status read before it moves a byte.

Two threshold registers compare against the queue levels and produce two level-sensitive pending bits. One bit means the transmit queue is running low. The other means the receive queue holds more than a chosen number of bytes. An enable register masks the pending bits into a single registered interrupt line. A driver sets the receive threshold to n-1 to be told once n bytes have arrived.

Register word addresses: 0 transmit data, 1 receive data, 2 transmit threshold, 3 receive threshold, 4 interrupt enable, 5 pending. Every register read returns its data on `reg_rdata` one clock after `reg_rd` is sampled high. An engine pop returns its byte on `eng_tx_data` one clock after `eng_tx_pop` is sampled high.

Top module: `spi_fifo_pair`

## Requirements
- R1: A write to address 0 enqueues `reg_wdata[7:0]` into the transmit queue. Engine pops return the bytes in write order on `eng_tx_data`, one cycle after each pop. `eng_tx_avail` is high while the queue is not empty.
- R2: A read of address 0 returns bit 31 set when the transmit queue holds DEPTH bytes and clear otherwise. Bits 30:0 read as zero.
- R3: A write to address 0 while the transmit queue is full is dropped. The queue contents and order are unchanged.
- R4: An `eng_rx_push` enqueues `eng_rx_data`. A read of address 1 dequeues the oldest byte and returns it in bits 7:0 with bit 31 clear and all other bits zero.
- R5: A read of address 1 while the receive queue is empty returns 0x80000000 and leaves the queue unchanged.
- R6: An `eng_rx_push` while the receive queue is full is dropped.
- R7: After reset both queues are empty, the transmit threshold reads 1, the receive threshold reads 0, the enable reads 0, the pending register reads 0x1 and `irq` is low.
- R8: Pending bit 0 is set exactly while the transmit queue count is strictly less than the transmit threshold.
- R9: Pending bit 1 is set exactly while the receive queue count is strictly greater than the receive threshold, so a threshold of n-1 signals once n bytes are held.
- R10: `irq` equals the OR over the pending bits ANDed with enable bits 1:0. It follows the pending state with one clock of delay.
- R11: The pending register is read-only: writes to address 5 have no effect. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Popped byte, valid one cycle after the pop |
| eng_rx_push | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | 8 | Received byte |
| irq | output | 1 | Masked watermark interrupt |

## Verification
A wrong queue count shows up in the next pending-register read, and on `irq` one clock later, as soon as the count crosses a threshold. Its full or empty flag in bit 31 also goes wrong at the boundary. A corrupted pointer shows up at the first pop or read whose byte differs from the order of the model. A dropped-write error appears at the first write to a full queue, because every later byte then shifts. The random phase sweeps the thresholds across all levels, so a comparison off by one shows up within a few operations.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_TXDATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_RXDATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXMARK = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXMARK = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEND   = 3'd5;
  localparam int FLAG_BIT = 31;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (count == '0)); // R5
endmodule

// File: rtl/spi_wm_irq.sv
module spi_wm_irq #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_txmark,
  input  logic          wr_rxmark,
  input  logic          wr_enable,
  input  logic [31:0]   wdata,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_mark,
  output logic [CW-1:0] rx_mark,
  output logic [1:0]    enable,
  output logic [1:0]    pend,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_mark <= CW'(1);
      rx_mark <= '0;
      enable  <= '0;
    end else begin
      if (wr_txmark) tx_mark <= wdata[CW-1:0];
      if (wr_rxmark) rx_mark <= wdata[CW-1:0];
      if (wr_enable) enable  <= wdata[1:0];
    end
  end

  assign pend[0] = (tx_count < tx_mark);
  assign pend[1] = (rx_count > rx_mark);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & enable);
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(enable) != 2'b00)); // R10
  AST_RESET_MARKS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_mark == CW'(1) && rx_mark == '0 && enable == '0)); // R7
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_tx_avail,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  output logic              irq
);
  logic [CW-1:0] tx_count, rx_count, tx_mark, rx_mark;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]    rx_dout;
  logic [1:0]    enable, pend;
  logic [31:0]   rdata_q;
  logic          sel_rx_q, rx_empty_q;
  logic          rd_rx;

  assign rd_rx = reg_rd && (reg_addr == A_RXDATA);

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst(rst),
    .push(reg_wr && (reg_addr == A_TXDATA)), .din(reg_wdata[7:0]),
    .pop(eng_tx_pop), .dout(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst(rst),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_rx), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  spi_wm_irq #(.DEPTH(DEPTH)) u_wm (
    .clk(clk), .rst(rst),
    .wr_txmark(reg_wr && (reg_addr == A_TXMARK)),
    .wr_rxmark(reg_wr && (reg_addr == A_RXMARK)),
    .wr_enable(reg_wr && (reg_addr == A_ENABLE)),
    .wdata(reg_wdata),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_mark(tx_mark), .rx_mark(rx_mark),
    .enable(enable), .pend(pend), .irq(irq)
  );

  assign eng_tx_avail = !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      sel_rx_q   <= 1'b0;
      rx_empty_q <= 1'b0;
    end else begin
      sel_rx_q   <= rd_rx;
      rx_empty_q <= rx_empty;
      rdata_q    <= '0;
      if (reg_rd) begin
        case (reg_addr)
          A_TXDATA: rdata_q[FLAG_BIT] <= tx_full;
          A_TXMARK: rdata_q[CW-1:0]   <= tx_mark;
          A_RXMARK: rdata_q[CW-1:0]   <= rx_mark;
          A_ENABLE: rdata_q[1:0]      <= enable;
          A_PEND:   rdata_q[1:0]      <= pend;
          default:  rdata_q           <= '0;
        endcase
      end
    end
  end

  always_comb begin
    if (sel_rx_q)
      reg_rdata = rx_empty_q ? (32'd1 << FLAG_BIT) : {24'd0, rx_dout};
    else
      reg_rdata = rdata_q;
  end

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && rx_empty) |=> (reg_rdata == 32'h8000_0000)); // R5
  AST_TX_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_TXDATA && tx_full) |=> reg_rdata[31]); // R2
  AST_AVAIL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_pop && eng_tx_avail && !(reg_wr && reg_addr == A_TXDATA) && tx_count == CW'(1))
      |=> !eng_tx_avail); // R1
endmodule

// File: tb/sim_spi_fifo_pair.sv
module sim_spi_fifo_pair;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] eng_tx_data, eng_rx_data = '0;
  logic eng_tx_avail, irq;

  int checks = 0, fails = 0;
  byte unsigned txq[$], rxq[$];
  int txm = 1, rxm = 0, ien = 0;

  always #2.5 clk = ~clk;

  spi_fifo_pair #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pend();
    logic [31:0] p = '0;
    p[0] = (txq.size() < txm);
    p[1] = (rxq.size() > rxm);
    return p;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a == 3'd0 && txq.size() < DEPTH) txq.push_back(d[7:0]);
    if (a == 3'd2) txm = d[3:0];
    if (a == 3'd3) rxm = d[3:0];
    if (a == 3'd4) ien = d[1:0];
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] q);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; q = reg_rdata;
  endtask

  task automatic check_rx();
    logic [31:0] q, e;
    e = (rxq.size() == 0) ? 32'h8000_0000 : {24'd0, rxq[0]};
    if (rxq.size() != 0) void'(rxq.pop_front());
    rd(3'd1, q);
    chk((e[31] ? "R5" : "R4"), q, e);
  endtask

  task automatic eng_pop();
    @(negedge clk); eng_tx_pop = 1;
    @(negedge clk); eng_tx_pop = 0;
    if (txq.size() != 0) chk("R1", {24'd0, eng_tx_data}, {24'd0, txq.pop_front()});
  endtask

  task automatic eng_push(input byte unsigned b);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = b;
    @(negedge clk); eng_rx_push = 0;
    if (rxq.size() < DEPTH) rxq.push_back(b);
  endtask

  task automatic check_status();
    logic [31:0] q, p;
    p = exp_pend();
    rd(3'd5, q);
    chk("R8 R9", q, p);
    chk("R10", {31'd0, irq}, {31'd0, |(p[1:0] & ien[1:0])});
    rd(3'd0, q);
    chk("R2", q, (txq.size() == DEPTH) ? 32'h8000_0000 : 32'h0);
    chk("R1 avail", {31'd0, eng_tx_avail}, {31'd0, txq.size() != 0});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] q;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 reset state
    rd(3'd2, q); chk("R7 txmark", q, 32'd1);
    rd(3'd3, q); chk("R7 rxmark", q, 32'd0);
    rd(3'd4, q); chk("R7 enable", q, 32'd0);
    rd(3'd5, q); chk("R7 pend", q, 32'h1);
    chk("R7 irq", {31'd0, irq}, 32'd0);
    check_rx();                                  // R5 empty read
    // R11 pending is read-only, unused reads zero
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, q); chk("R11", q, 32'h1);
    rd(3'd7, q); chk("R11 unused", q, 32'h0);
    // R3 fill transmit queue then overflow
    for (int i = 0; i < DEPTH + 2; i++) wr(3'd0, 32'hA0 + i);
    check_status();
    for (int i = 0; i < DEPTH; i++) eng_pop();
    // R6 fill receive queue then overflow, R9 mark n-1
    wr(3'd3, 32'd3); wr(3'd4, 32'd2);
    for (int i = 0; i < DEPTH + 2; i++) begin
      eng_push(8'h50 + i);
      check_status();
    end
    for (int i = 0; i < DEPTH + 1; i++) check_rx();
    // constrained random
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0, 1: wr(3'd0, $urandom);
        2: eng_pop();
        3: eng_push(8'($urandom));
        4: check_rx();
        default: wr(3'd2 + 3'($urandom % 3), $urandom % (DEPTH + 1));
      endcase
      check_status();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule